// File: doc/BRIEF.md
# UART Transmit Holding Buffer

This block sits between a register-bus writer and a UART serializer on the transmit side. Software stores characters by writing to a holding location. The block shows whether transmit storage is empty and passes the stored characters to the serializer over a valid/ready handshake. A mode input chooses between two kinds of storage. One is a single holding register, where a later write replaces the byte that is still waiting. The other is a first-in first-out queue that holds up to 16 characters, and it drops writes that arrive while it is full.

The holding location answers at sixteen consecutive word addresses, so a bus master can issue a burst of writes to one register. Only the low byte of each 32-bit write is stored. When the mode input changes, the block empties all of its storage. Software is expected to write only while the empty flag is set. The block still behaves in a defined way when software writes at other times.

Top module: `txhold_buf`

## Requirements
- R1: After reset, `hold_empty` is 1 and `tx_valid` is 0.
- R2: A write is taken only when `wr_word` lies in the 16-word window starting at word 0x40 (0x40 to 0x4F). Writes to any other word have no effect. Only `wr_data[7:0]` is stored, and bits 31:8 are ignored.
- R3: In single mode (`fifo_mode`=0), a write taken while the register is empty clears `hold_empty`. From the next cycle, `tx_valid` is 1 and `tx_data` shows the written byte.
- R4: In single mode, a write taken while a byte is already waiting replaces that byte. Only the newest byte is handed to the serializer.
- R5: In single mode, a handshake (`tx_valid` and `tx_ready` both 1) sets `hold_empty` from the next cycle. If a write is taken in the same cycle as the handshake, the new byte is kept and `hold_empty` stays 0.
- R6: In queue mode (`fifo_mode`=1), characters leave in the order they were written, one for each handshake. `hold_empty` is 1 only when the queue holds no characters.
- R7: In queue mode, up to 16 characters can be stored. A write that arrives while 16 are stored is discarded, even when a handshake happens in the same cycle.
- R8: In a cycle where `fifo_mode` differs from its value at the previous clock edge, `tx_valid` is 0 and writes are ignored. From the next cycle, all storage is empty and `hold_empty` is 1.
- R9: In queue mode, while `tx_valid` is 1 and `tx_ready` is 0, `tx_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write strobe |
| wr_word | input | 8 | Word address of the write |
| wr_data | input | 32 | Write data; bits 7:0 carry the character |
| fifo_mode | input | 1 | 0 selects the single register, 1 selects the 16-deep queue |
| tx_valid | output | 1 | A character is offered to the serializer |
| tx_data | output | 8 | Character offered to the serializer |
| tx_ready | input | 1 | The serializer accepts the offered character |
| hold_empty | output | 1 | Transmit storage holds no character |

## Verification
The hardest case to reach from the ports is a write that arrives while the queue is exactly full and the serializer pops in the same cycle. Reaching it takes sixteen writes with no handshake, then one cycle in which the bench raises the write strobe and `tx_ready` together. The bench then drains the queue and expects exactly fifteen characters in order, with the late byte absent. The mode-change flush is reached by filling the queue, toggling `fifo_mode` in the same cycle as a write, and checking that neither the queued bytes nor the late write come out.

// File: rtl/txhold_pkg.sv
package txhold_pkg;
   typedef enum logic {MODE_SINGLE = 1'b0, MODE_QUEUE = 1'b1} txhold_mode_e;
   localparam int unsigned TXH_ALIAS_N = 16;
endpackage

// File: rtl/txhold_decode.sv
module txhold_decode #(
   parameter int unsigned WORD_W    = 8,
   parameter int unsigned BASE_WORD = 'h40,
   parameter int unsigned ALIAS_N   = txhold_pkg::TXH_ALIAS_N
) (
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_word,
   output logic              hit
);
   localparam int unsigned AW      = $clog2(ALIAS_N);
   localparam int unsigned BASE_HI = BASE_WORD >> AW;

   generate
      if ((1 << AW) != ALIAS_N) begin : g_bad_alias
         $error("ALIAS_N must be a power of two");
      end
      if ((BASE_WORD % ALIAS_N) != 0) begin : g_bad_base
         $error("BASE_WORD must be aligned to ALIAS_N");
      end
      if (AW >= WORD_W) begin : g_bad_width
         $error("WORD_W too small for the alias window");
      end
   endgenerate

   logic [AW-1:0] unused_low;
   assign unused_low = wr_word[AW-1:0];
   assign hit = wr_en && (wr_word[WORD_W-1:AW] == (WORD_W-AW)'(BASE_HI));
endmodule

// File: rtl/txhold_single.sv
module txhold_single #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              wr,
   input  logic [DATA_W-1:0] din,
   input  logic              pop,
   output logic [DATA_W-1:0] dout,
   output logic              empty
);
   logic              full_q;
   logic [DATA_W-1:0] data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         data_q <= '0;
      end else if (flush) begin
         full_q <= 1'b0;
      end else if (wr) begin
         full_q <= 1'b1;
         data_q <= din;
      end else if (pop) begin
         full_q <= 1'b0;
      end
   end

   assign dout  = data_q;
   assign empty = !full_q;

   // R4 / R5: a write always leaves a byte waiting, whatever the pop does
   assert_write_keeps_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !flush) |=> (!empty && dout == $past(din)));
endmodule

// File: rtl/txhold_fifo.sv
module txhold_fifo #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              push,
   input  logic [DATA_W-1:0] din,
   input  logic              pop,
   output logic [DATA_W-1:0] dout,
   output logic              empty
);
   localparam int unsigned PW = $clog2(DEPTH);
   localparam int unsigned CW = PW + 1;
   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

   generate
      if (DEPTH < 2 || (1 << PW) != DEPTH) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] mem_q [DEPTH];
   logic [PW-1:0]     rd_ptr_q, wr_ptr_q;
   logic [CW-1:0]     count_q;
   logic              push_ok, pop_ok;

   assign push_ok = push && (count_q != FULL_CNT);
   assign pop_ok  = pop && (count_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr_q <= '0;
         wr_ptr_q <= '0;
         count_q  <= '0;
      end else if (flush) begin
         rd_ptr_q <= '0;
         wr_ptr_q <= '0;
         count_q  <= '0;
      end else begin
         if (push_ok) wr_ptr_q <= wr_ptr_q + 1'b1;
         if (pop_ok)  rd_ptr_q <= rd_ptr_q + 1'b1;
         if (push_ok && !pop_ok)      count_q <= count_q + 1'b1;
         else if (pop_ok && !push_ok) count_q <= count_q - 1'b1;
      end
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                  mem_q[i] <= '0;
         else if (push_ok && !flush && wr_ptr_q == PW'(i)) mem_q[i] <= din;
      end
   end

   assign dout  = mem_q[rd_ptr_q];
   assign empty = (count_q == '0);

   assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= FULL_CNT);
   // R7: a push into a full queue does not raise the occupancy
   assert_full_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (count_q == FULL_CNT && push && !flush) |=> (count_q != FULL_CNT || !$past(pop)));
endmodule

// File: rtl/txhold_buf.sv
module txhold_buf #(
   parameter int unsigned WORD_W    = 8,
   parameter int unsigned BUS_W     = 32,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned DEPTH     = 16,
   parameter int unsigned BASE_WORD = 'h40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_word,
   input  logic [BUS_W-1:0]  wr_data,
   input  logic              fifo_mode,
   output logic              tx_valid,
   output logic [DATA_W-1:0] tx_data,
   input  logic              tx_ready,
   output logic              hold_empty
);
   import txhold_pkg::*;

   generate
      if (DATA_W >= BUS_W) begin : g_bad_data
         $error("DATA_W must be narrower than BUS_W");
      end
   endgenerate

   txhold_mode_e     mode_q;
   logic             mode_chg, hit, wr_take, pop;
   logic             s_empty, q_empty;
   logic [DATA_W-1:0] s_dout, q_dout, char_in;
   logic [BUS_W-DATA_W-1:0] unused_hi;

   assign unused_hi = wr_data[BUS_W-1:DATA_W];
   assign char_in   = wr_data[DATA_W-1:0];

   txhold_decode #(.WORD_W(WORD_W), .BASE_WORD(BASE_WORD)) u_dec (
      .wr_en(wr_en), .wr_word(wr_word), .hit(hit));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= MODE_SINGLE;
      else        mode_q <= txhold_mode_e'(fifo_mode);
   end

   assign mode_chg   = (fifo_mode != mode_q);
   assign wr_take    = hit && !mode_chg;
   assign hold_empty = (mode_q == MODE_QUEUE) ? q_empty : s_empty;
   assign tx_data    = (mode_q == MODE_QUEUE) ? q_dout : s_dout;
   assign tx_valid   = !mode_chg && !hold_empty;
   assign pop        = tx_valid && tx_ready;

   txhold_single #(.DATA_W(DATA_W)) u_single (
      .clk(clk), .rst_n(rst_n), .flush(mode_chg),
      .wr(wr_take && mode_q == MODE_SINGLE), .din(char_in),
      .pop(pop && mode_q == MODE_SINGLE), .dout(s_dout), .empty(s_empty));

   txhold_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .flush(mode_chg),
      .push(wr_take && mode_q == MODE_QUEUE), .din(char_in),
      .pop(pop && mode_q == MODE_QUEUE), .dout(q_dout), .empty(q_empty));

   assert_single_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_SINGLE && !mode_chg && hit && hold_empty) |=> (tx_valid && !hold_empty));
   assert_flush_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mode_chg |=> hold_empty);
   assert_no_offer_on_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mode_chg |-> !tx_valid);
   assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_QUEUE && tx_valid && !tx_ready && !mode_chg && fifo_mode)
      |=> $stable(tx_data));
   assert_outside_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit && hold_empty && !tx_ready) |=> hold_empty);
endmodule

// File: tb/sim_txhold_buf.sv
module sim_txhold_buf;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_word = '0;
   logic [31:0] wr_data = '0;
   logic        fifo_mode = 1'b0;
   logic        tx_valid, hold_empty, tx_ready = 1'b0;
   logic [7:0]  tx_data;
   int total = 0, bad = 0;

   always #10 clk = ~clk;

   txhold_buf u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word),
      .wr_data(wr_data), .fifo_mode(fifo_mode), .tx_valid(tx_valid),
      .tx_data(tx_data), .tx_ready(tx_ready), .hold_empty(hold_empty));

   // {word, data}; written in queue mode
   localparam logic [15:0] VEC [10] = '{
      16'h40_11, 16'h4F_22, 16'h3F_33, 16'h47_44, 16'h50_55,
      16'hC0_66, 16'h41_77, 16'h00_88, 16'h4A_99, 16'h4E_AA};

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] w, input logic [31:0] d);
      @(negedge clk); wr_en = 1'b1; wr_word = w; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic pop_chk(input logic [7:0] exp, input string req);
      @(negedge clk);
      chk(tx_valid && tx_data == exp, req, {tx_valid, tx_data}, {1'b1, exp});
      tx_ready = 1'b1;
      @(negedge clk); tx_ready = 1'b0;
   endtask

   task automatic set_mode(input logic m);
      @(negedge clk); fifo_mode = m;
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] expq [$];
      repeat (3) @(negedge clk);
      // R1
      chk(hold_empty && !tx_valid, "R1", {hold_empty, tx_valid}, 2'b10);
      rst_n = 1'b1;
      @(negedge clk);
      chk(hold_empty && !tx_valid, "R1", {hold_empty, tx_valid}, 2'b10);

      // vector walk, queue mode: R2 window, R6 order
      set_mode(1'b1);
      foreach (VEC[i]) begin
         wr(VEC[i][15:8], {24'hABCDEF, VEC[i][7:0]});
         if (VEC[i][15:8] >= 8'h40 && VEC[i][15:8] <= 8'h4F) expq.push_back(VEC[i][7:0]);
      end
      chk(!hold_empty, "R6", hold_empty, 0);
      while (expq.size() > 0) pop_chk(expq.pop_front(), "R2/R6");
      @(negedge clk);
      chk(hold_empty && !tx_valid, "R6", {hold_empty, tx_valid}, 2'b10);

      // R9: data held while not ready
      wr(8'h40, 32'h5A); wr(8'h40, 32'hA5);
      repeat (3) @(negedge clk);
      chk(tx_data == 8'h5A, "R9", tx_data, 8'h5A);
      pop_chk(8'h5A, "R9"); pop_chk(8'hA5, "R6");

      // R7: fill, then write while full together with a pop
      for (int i = 0; i < 16; i++) wr(8'h40 + 8'(i), 32'(8'h10 + i));
      wr(8'h40, 32'hEE);
      @(negedge clk); wr_en = 1'b1; wr_word = 8'h43; wr_data = 32'hEF; tx_ready = 1'b1;
      @(negedge clk); wr_en = 1'b0; tx_ready = 1'b0;
      for (int i = 1; i < 16; i++) pop_chk(8'(8'h10 + i), "R7");
      @(negedge clk);
      chk(hold_empty && !tx_valid, "R7", {hold_empty, tx_valid}, 2'b10);

      // R8: flush on mode change, write in change cycle ignored
      wr(8'h40, 32'h31); wr(8'h41, 32'h32);
      @(negedge clk); fifo_mode = 1'b0; wr_en = 1'b1; wr_word = 8'h40; wr_data = 32'h77;
      #1 chk(!tx_valid, "R8", tx_valid, 0);
      @(negedge clk); wr_en = 1'b0;
      chk(hold_empty && !tx_valid, "R8", {hold_empty, tx_valid}, 2'b10);

      // R3, R4 single mode
      wr(8'h45, 32'hFFFF_FF21);
      chk(!hold_empty && tx_valid && tx_data == 8'h21, "R3", tx_data, 8'h21);
      wr(8'h4C, 32'h22);
      wr(8'h20, 32'h23);
      pop_chk(8'h22, "R4");
      @(negedge clk);
      chk(hold_empty && !tx_valid, "R5", {hold_empty, tx_valid}, 2'b10);

      // R5: write and pop in the same cycle keeps the new byte
      wr(8'h40, 32'h61);
      @(negedge clk); wr_en = 1'b1; wr_word = 8'h40; wr_data = 32'h62; tx_ready = 1'b1;
      @(negedge clk); wr_en = 1'b0; tx_ready = 1'b0;
      chk(!hold_empty && tx_data == 8'h62, "R5", tx_data, 8'h62);
      pop_chk(8'h62, "R5");
      @(negedge clk);
      chk(hold_empty, "R5", hold_empty, 1);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule